// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small stored-program processor that runs one instruction at a time through a fixed fetch, decode and execute sequence. It holds a single accumulator, a program counter, an instruction register, a three-flag condition register (greater, equal, less) and an on-chip word memory. That memory holds the program and its data together, and all traffic to it goes through an address latch and a data latch. Every instruction names one memory word. Arithmetic works between the accumulator and that word, or changes the word in place. A compare sets the condition flags, and four conditional jump kinds test them.

Integers enter through a ready/valid input port. The processor waits on an input instruction until a value is offered. Results leave on a one-cycle valid output strobe. A halt instruction parks the core, and it stays parked until reset. The memory image is preloaded while reset is held. Execution then starts at address 0.

Top module: `cpu_core`

## Requirements
- R1: While reset is low and right after it, `halted`, `out_valid` and `in_ready` are low. The accumulator, the PC and all flags are zero, and execution begins by fetching the word at address 0.
- R2: An instruction word carries the operation code in bits [15:12] and an address in bits [11:0]. The PC advances by one on every fetch. An address selects the memory word given by its low log2(MEM_WORDS) bits.
- R3: Code 0000 copies the word into the accumulator. Code 0001 writes the accumulator to the word. Code 0010 writes zero to the word.
- R4: Code 0011 adds the word to the accumulator and code 0101 subtracts the word from it. Both wrap modulo 2^16.
- R5: Code 0100 writes the word plus one back to the same address, and code 0110 writes the word minus one. Both wrap modulo 2^16.
- R6: Code 0111 compares the word with the accumulator as signed values. Afterwards exactly one flag is set: greater (word > acc), equal, or less. No other instruction changes the flags.
- R7: Code 1000 always loads the address into the PC. Codes 1001, 1010 and 1011 do so only when the greater, equal or less flag is set. Code 1100 does so when the equal flag is clear.
- R8: Code 1101 holds `in_ready` high until `in_valid` is seen. It then stores `in_data` at the address.
- R9: Code 1110 raises `out_valid` for exactly one cycle, with the addressed word on `out_data`.
- R10: Code 1111 raises `halted`, which stays high until reset. While halted, no output strobe and no input request occur.
- R11: Counted in clock edges from the first fetch edge, instruction lengths are fixed. Jumps and halt take 4 edges. Load, add, subtract, compare, output, store and clear take 6. Increment and decrement take 7. Input takes 6 plus the number of cycles `in_ready` waits for `in_valid`. The output strobe appears after the 6th edge of its instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 16 | Integer offered to an input instruction |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | An input instruction is waiting for a value |
| out_data | output | 16 | Word produced by an output instruction |
| out_valid | output | 1 | One-cycle strobe qualifying `out_data` |
| halted | output | 1 | Core has executed halt |

## Verification
The bench builds the core with its default parameters: 16-bit data, 12-bit instruction addresses and a 256-word memory. With these values the address fields above 255 fold onto low memory, so an instruction that names address 366 can be used to confirm the modulo selection. Signed compares are checked with negative words against a positive accumulator, and arithmetic is checked across the 0x7FFF/0x8000 and 0x0000/0xFFFF boundaries. The same input program runs with zero and three cycles of input delay, which exercises the stall path.

// File: rtl/cpu_pkg.sv
// Package: operation codes, sequencer states, flag record and decode
// helpers shared by the processor's modules.
// Assumes a 4-bit operation code in the top bits of an instruction word.
package cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'h0, OP_STORE = 4'h1, OP_CLEAR = 4'h2, OP_ADD  = 4'h3,
        OP_INC   = 4'h4, OP_SUB   = 4'h5, OP_DEC   = 4'h6, OP_CMP  = 4'h7,
        OP_JMP   = 4'h8, OP_JGT   = 4'h9, OP_JEQ   = 4'hA, OP_JLT  = 4'hB,
        OP_JNE   = 4'hC, OP_IN    = 4'hD, OP_OUT   = 4'hE, OP_HALT = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        ST_F_MAR, ST_F_RD, ST_F_IR, ST_DEC, ST_X_RD, ST_X_OP, ST_X_WR, ST_HALT
    } st_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } flags_t;

    // True for the five jump kinds
    function automatic logic is_jump(op_e op);
        return (op == OP_JMP) || (op == OP_JGT) || (op == OP_JEQ) ||
               (op == OP_JLT) || (op == OP_JNE);
    endfunction

    // True when a jump kind transfers control under the given flags
    function automatic logic jump_taken(op_e op, flags_t f);
        case (op)
            OP_JMP:  return 1'b1;
            OP_JGT:  return f.gt;
            OP_JEQ:  return f.eq;
            OP_JLT:  return f.lt;
            OP_JNE:  return !f.eq;
            default: return 1'b0;
        endcase
    endfunction

    // True when execution needs the addressed word read into the data latch
    function automatic logic reads_mem(op_e op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) ||
               (op == OP_INC)  || (op == OP_DEC) || (op == OP_CMP) ||
               (op == OP_OUT);
    endfunction

    // True when execution ends with a write of the data latch to memory
    function automatic logic writes_mem(op_e op);
        return (op == OP_STORE) || (op == OP_CLEAR) || (op == OP_INC) ||
               (op == OP_DEC)   || (op == OP_IN);
    endfunction

endpackage

// File: rtl/cpu_mem.sv
// Module: word memory with its address latch and data latch.
// Reads land in the data latch one edge after rd_en. A write stores the
// data latch at the latched address. The array itself is not reset; it
// is expected to be preloaded while the core is held in reset.
module cpu_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mar_ld,
    input  logic [AW-1:0]     mar_d,
    input  logic              rd_en,
    input  logic              mdr_ld,
    input  logic [DATA_W-1:0] mdr_d,
    input  logic              wr_en,
    output logic [DATA_W-1:0] mdr
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     mar_q;
    logic [DATA_W-1:0] mdr_q;

    // Address latch: loaded by the sequencer before each access
    always_ff @(posedge clk) begin
        if (!rst_n)      mar_q <= '0;
        else if (mar_ld) mar_q <= mar_d;
    end

    // Data latch: memory read has priority over a datapath load
    always_ff @(posedge clk) begin
        if (!rst_n)      mdr_q <= '0;
        else if (rd_en)  mdr_q <= mem_q[mar_q];
        else if (mdr_ld) mdr_q <= mdr_d;
    end

    // Array write strobe: commit the data latch at the latched address
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[mar_q] <= mdr_q;
    end

    assign mdr = mdr_q;

endmodule

// File: rtl/cpu_alu.sv
// Module: combinational arithmetic for the processor.
// Produces the next accumulator value, the value to write back to memory
// and the compare flags for the current operation. All arithmetic wraps.
// The compare is signed and always yields exactly one flag.
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] acc_next,
    output logic [DATA_W-1:0] mem_next,
    output flags_t            flags_next
);

    // Accumulator result of load, add and subtract
    always_comb begin
        case (op)
            OP_LOAD: acc_next = opnd;
            OP_ADD:  acc_next = acc + opnd;
            OP_SUB:  acc_next = acc - opnd;
            default: acc_next = acc;
        endcase
    end

    // Write-back value for store, clear, increment and decrement
    always_comb begin
        case (op)
            OP_STORE: mem_next = acc;
            OP_CLEAR: mem_next = '0;
            OP_INC:   mem_next = opnd + 1'b1;
            OP_DEC:   mem_next = opnd - 1'b1;
            default:  mem_next = opnd;
        endcase
    end

    // Signed three-way compare of the memory word against the accumulator
    always_comb begin
        flags_next.gt = $signed(opnd) >  $signed(acc);
        flags_next.eq = opnd == acc;
        flags_next.lt = $signed(opnd) <  $signed(acc);
    end

endmodule

// File: rtl/cpu_ctrl.sv
// Module: instruction sequencer.
// Steps fetch (address, read, latch), decode and execute (read, operate,
// write) states. Jumps finish in decode. Input waits in the operate
// state for in_valid. Halt is terminal until reset.
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    input  logic in_valid,
    output st_e  state
);

    st_e state_q, state_d;

    // Next-state selection for the fetch/decode/execute loop
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_F_MAR: state_d = ST_F_RD;
            ST_F_RD:  state_d = ST_F_IR;
            ST_F_IR:  state_d = ST_DEC;
            ST_DEC: begin
                if (op == OP_HALT)      state_d = ST_HALT;
                else if (is_jump(op))   state_d = ST_F_MAR;
                else if (reads_mem(op)) state_d = ST_X_RD;
                else                    state_d = ST_X_OP;
            end
            ST_X_RD:  state_d = ST_X_OP;
            ST_X_OP: begin
                if (op == OP_IN)         state_d = in_valid ? ST_X_WR : ST_X_OP;
                else if (writes_mem(op)) state_d = ST_X_WR;
                else                     state_d = ST_F_MAR;
            end
            ST_X_WR:  state_d = ST_F_MAR;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_F_MAR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_F_MAR;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/cpu_core.sv
// Module: top of the accumulator processor.
// Holds the PC, instruction register, accumulator, flags and output
// register, and drives the memory latches from the sequencer state.
// Assumes DATA_W == 4 + ADDR_W and MEM_WORDS <= 2**ADDR_W; addresses
// fold onto memory by their low bits.
module cpu_core
    import cpu_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int MEM_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              halted
);

    localparam int MAW = $clog2(MEM_WORDS);

    st_e               state;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    flags_t            flags_q;
    logic [DATA_W-1:0] out_q;
    logic              out_v_q;
    logic [DATA_W-1:0] mdr;
    logic [DATA_W-1:0] acc_next, mem_next;
    flags_t            flags_next;
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic              mar_ld, rd_en, mdr_ld, wr_en;
    logic [MAW-1:0]    mar_d;
    logic [DATA_W-1:0] mdr_d;

    assign op   = op_e'(ir_q[DATA_W-1 -: OPC_W]);
    assign addr = ir_q[ADDR_W-1:0];

    cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .in_valid (in_valid),
        .state    (state)
    );

    cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op         (op),
        .acc        (acc_q),
        .opnd       (mdr),
        .acc_next   (acc_next),
        .mem_next   (mem_next),
        .flags_next (flags_next)
    );

    // Memory latch strobes derived from the sequencer state
    always_comb begin
        mar_ld = (state == ST_F_MAR) ||
                 (state == ST_DEC && !is_jump(op) && op != OP_HALT);
        mar_d  = (state == ST_F_MAR) ? pc_q[MAW-1:0] : addr[MAW-1:0];
        rd_en  = (state == ST_F_RD) || (state == ST_X_RD);
        mdr_ld = (state == ST_X_OP) && writes_mem(op) &&
                 (op != OP_IN || in_valid);
        mdr_d  = (op == OP_IN) ? in_data : mem_next;
        wr_en  = (state == ST_X_WR);
    end

    cpu_mem #(.DATA_W(DATA_W), .DEPTH(MEM_WORDS)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .mar_ld (mar_ld),
        .mar_d  (mar_d),
        .rd_en  (rd_en),
        .mdr_ld (mdr_ld),
        .mdr_d  (mdr_d),
        .wr_en  (wr_en),
        .mdr    (mdr)
    );

    // Program counter: step on fetch, reload on a taken jump
    always_ff @(posedge clk) begin
        if (!rst_n)                                      pc_q <= '0;
        else if (state == ST_F_IR)                       pc_q <= pc_q + 1'b1;
        else if (state == ST_DEC && jump_taken(op, flags_q)) pc_q <= addr;
    end

    // Instruction register: captures the fetched word
    always_ff @(posedge clk) begin
        if (!rst_n)                ir_q <= '0;
        else if (state == ST_F_IR) ir_q <= mdr;
    end

    // Accumulator: updated by load, add and subtract
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else if (state == ST_X_OP &&
                 (op == OP_LOAD || op == OP_ADD || op == OP_SUB))
            acc_q <= acc_next;
    end

    // Condition flags: written by compare only
    always_ff @(posedge clk) begin
        if (!rst_n)                                   flags_q <= '0;
        else if (state == ST_X_OP && op == OP_CMP)    flags_q <= flags_next;
    end

    // Output register: one-cycle strobe carrying the addressed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v_q <= 1'b0;
            out_q   <= '0;
        end else begin
            out_v_q <= (state == ST_X_OP) && (op == OP_OUT);
            if (state == ST_X_OP && op == OP_OUT) out_q <= mdr;
        end
    end

    assign in_ready  = (state == ST_X_OP) && (op == OP_IN);
    assign out_valid = out_v_q;
    assign out_data  = out_q;
    assign halted    = (state == ST_HALT);

endmodule

// File: rtl/cpu_core_chk.sv
// Module: property checker for cpu_core, attached by bind.
// Watches ports together with the sequencer state, PC and flags.
module cpu_core_chk
    import cpu_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input st_e               state,
    input op_e               op,
    input logic [ADDR_W-1:0] pc,
    input flags_t            flags,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              halted
);

    // PC steps by one across the latch stage of a fetch
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F_IR) |=> (pc == $past(pc) + 1'b1));

    // Flags never carry more than one set bit
    assert_flags_onehot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    // A compare leaves exactly one flag set
    assert_cmp_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_X_OP && op == OP_CMP) |=> ($countones(flags) == 1));

    // Flags move only after a compare operate cycle
    assert_flags_only_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != $past(flags)) |-> ($past(state) == ST_X_OP && $past(op) == OP_CMP));

    // Input request is held until a value is offered
    assert_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

    // Output strobe lasts a single cycle
    assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // Halt is sticky
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // A halted core neither outputs nor requests input
    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!out_valid && !in_ready));

endmodule

bind cpu_core cpu_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .op        (op),
    .pc        (pc_q),
    .flags     (flags_q),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .halted    (halted)
);

// File: tb/test_cpu_core.sv
`timescale 1ns/1ps
// Bench: loads a program image, runs a behavioural instruction-level
// model that predicts per-edge outputs, and compares the ports every cycle.
module test_cpu_core;

    localparam int MW   = 256;
    localparam int MAXE = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] out_data;
    logic        out_valid;
    logic        halted;

    int errs = 0;
    int checks = 0;
    int e = 0;
    int total_cyc = 0;
    bit wd_hit = 0;

    logic [15:0] img [MW];
    logic [15:0] inq [$];
    logic [15:0] min_q [$];
    bit          exp_ov  [MAXE];
    logic [15:0] exp_od  [MAXE];
    bit          exp_rdy [MAXE];
    int          halt_e;

    cpu_core i_cpu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .halted    (halted)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) e <= 0;
        else        e <= e + 1;
        total_cyc <= total_cyc + 1;
    end

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s act=%h exp=%h edge=%0d", tag, what, act, exp, e);
        end
    endtask

    task automatic put(input int a, input logic [3:0] op, input int x);
        img[a] = {op, x[11:0]};
    endtask

    task automatic clear_img();
        for (int a = 0; a < MW; a++) img[a] = 16'h0000;
    endtask

    // Behavioural model: instruction-level execution with edge accounting
    task automatic run_model(input int dly);
        logic [15:0] m [MW];
        logic [11:0] pc;
        logic [15:0] acc, w;
        logic [3:0]  op;
        int          x, c;
        bit          gt, eq, lt, done;
        for (int i = 0; i < MAXE; i++) begin
            exp_ov[i] = 0; exp_od[i] = '0; exp_rdy[i] = 0;
        end
        for (int a = 0; a < MW; a++) m[a] = img[a];
        min_q = inq;
        pc = '0; acc = '0; gt = 0; eq = 0; lt = 0; c = 0; done = 0;
        halt_e = MAXE + 100;
        for (int n = 0; n < 600 && !done; n++) begin
            w  = m[pc % MW];
            op = w[15:12];
            x  = int'(w[11:0]) % MW;
            pc = pc + 12'd1;
            case (op)
                4'h0: begin acc = m[x]; c += 6; end
                4'h1: begin m[x] = acc; c += 6; end
                4'h2: begin m[x] = '0; c += 6; end
                4'h3: begin acc = acc + m[x]; c += 6; end
                4'h4: begin m[x] = m[x] + 16'd1; c += 7; end
                4'h5: begin acc = acc - m[x]; c += 6; end
                4'h6: begin m[x] = m[x] - 16'd1; c += 7; end
                4'h7: begin
                    gt = $signed(m[x]) > $signed(acc);
                    eq = m[x] == acc;
                    lt = $signed(m[x]) < $signed(acc);
                    c += 6;
                end
                4'h8, 4'h9, 4'hA, 4'hB, 4'hC: begin
                    if (op == 4'h8 || (op == 4'h9 && gt) || (op == 4'hA && eq) ||
                        (op == 4'hB && lt) || (op == 4'hC && !eq))
                        pc = w[11:0];
                    c += 4;
                end
                4'hD: begin
                    for (int k = 0; k <= dly; k++)
                        if (c + 4 + k < MAXE) exp_rdy[c + 4 + k] = 1;
                    m[x] = min_q.pop_front();
                    c += 6 + dly;
                end
                4'hE: begin
                    if (c + 6 < MAXE) begin exp_ov[c + 6] = 1; exp_od[c + 6] = m[x]; end
                    c += 6;
                end
                default: begin halt_e = c + 4; done = 1; end
            endcase
        end
    endtask

    // Reset, preload, predict, then compare ports on every cycle
    task automatic run_prog(input string tag, input int dly);
        int wcnt;
        bit fin;
        rst_n = 1'b0;
        in_valid = 1'b0;
        for (int a = 0; a < MW; a++) i_cpu_core.u_mem.mem_q[a] = img[a];
        run_model(dly);
        repeat (3) @(negedge clk);
        chk({tag, " R1"}, "halted in reset", {15'd0, halted}, 16'd0);
        chk({tag, " R1"}, "out_valid in reset", {15'd0, out_valid}, 16'd0);
        chk({tag, " R1"}, "in_ready in reset", {15'd0, in_ready}, 16'd0);
        rst_n = 1'b1;
        wcnt = 0;
        fin = 0;
        while (!fin) begin
            @(negedge clk);
            if (e < MAXE) begin
                chk({tag, " R10 R11"}, "halted", {15'd0, halted},
                    {15'd0, (e >= halt_e)});
                chk({tag, " R9 R11"}, "out_valid", {15'd0, out_valid},
                    {15'd0, exp_ov[e]});
                if (exp_ov[e])
                    chk({tag, " R9"}, "out_data", out_data, exp_od[e]);
                chk({tag, " R8 R11"}, "in_ready", {15'd0, in_ready},
                    {15'd0, exp_rdy[e]});
            end
            // Input driver: wait dly requesting cycles, then offer one value
            if (in_valid) begin
                void'(inq.pop_front());
                in_valid = 1'b0;
                wcnt = 0;
            end else if (in_ready && inq.size() > 0) begin
                if (wcnt < dly) wcnt++;
                else begin in_valid = 1'b1; in_data = inq[0]; end
            end
            if (e >= halt_e + 12) fin = 1;
            if (e >= MAXE - 1 || total_cyc > 150000) begin
                errs++; checks++; wd_hit = 1; fin = 1;
                $display("FAIL %s watchdog act=edge %0d exp=halt by %0d", tag, e, halt_e);
            end
        end
    endtask

    initial begin
        // Program A: load/store/clear, wrapping arithmetic, in-place inc/dec,
        // address folding (366 -> 110)
        clear_img();
        put(0, 4'h0, 100); put(1, 4'h3, 101); put(2, 4'h1, 110); put(3, 4'hE, 110);
        put(4, 4'h5, 102); put(5, 4'h1, 111); put(6, 4'hE, 111); put(7, 4'h4, 103);
        put(8, 4'hE, 103); put(9, 4'h6, 104); put(10, 4'hE, 104); put(11, 4'h2, 105);
        put(12, 4'hE, 105); put(13, 4'h0, 106); put(14, 4'h1, 107); put(15, 4'hE, 107);
        put(16, 4'hE, 366); put(17, 4'hF, 0);
        img[100] = 16'h7FFF; img[101] = 16'h0001; img[102] = 16'h0003;
        img[103] = 16'hFFFF; img[104] = 16'h0000; img[105] = 16'h1234;
        img[106] = 16'hA5A5;
        run_prog("progA R1 R2 R3 R4 R5", 0);

        // Program B: signed compare and every jump kind, taken and not taken
        clear_img();
        put(0, 4'h0, 200); put(1, 4'h7, 201); put(2, 4'h9, 40); put(3, 4'hA, 40);
        put(4, 4'hC, 6);   put(5, 4'hE, 202); put(6, 4'hB, 8);  put(7, 4'hE, 202);
        put(8, 4'hE, 203); put(9, 4'h7, 204); put(10, 4'h3, 205); put(11, 4'h9, 13);
        put(12, 4'hE, 202); put(13, 4'h7, 206); put(14, 4'hA, 16); put(15, 4'hE, 202);
        put(16, 4'hC, 40); put(17, 4'hB, 40); put(18, 4'h9, 40); put(19, 4'h8, 21);
        put(20, 4'hE, 202); put(21, 4'hE, 207); put(22, 4'hF, 0);
        put(40, 4'hE, 202); put(41, 4'hF, 0);
        img[200] = 16'h0005; img[201] = 16'hFFFD; img[202] = 16'hDEAD;
        img[203] = 16'h0A01; img[204] = 16'h0007; img[205] = 16'h0001;
        img[206] = 16'h0006; img[207] = 16'h0A02;
        run_prog("progB R6 R7", 0);

        // Program C: input with no delay, then with three wait cycles
        clear_img();
        put(0, 4'hD, 150); put(1, 4'hD, 151); put(2, 4'h0, 150); put(3, 4'h3, 151);
        put(4, 4'h1, 152); put(5, 4'hE, 152); put(6, 4'hE, 150); put(7, 4'hF, 0);
        inq = '{16'h0102, 16'h0304};
        run_prog("progC0 R8 R9", 0);
        inq = '{16'hFFF0, 16'h0020};
        run_prog("progC3 R8 R9", 3);

        // Program D: halt is sticky; code after it never runs
        clear_img();
        put(0, 4'hE, 5); put(1, 4'hF, 0); put(2, 4'hE, 5); put(3, 4'hD, 6);
        img[5] = 16'h0055;
        run_prog("progD R10", 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule